// File: doc/BRIEF.md
# Bus parity generator and checker

This block sits beside the address/data pads of a PCI-style bus agent. It produces even parity for the lower 32-bit lane, together with its four command/byte-enable lines, and optionally for the upper 32-bit lane with its four lines. It works out from the bus handshake when the agent must drive parity and when it must check the parity that another agent drives. A role input tells it whether the agent is the initiator (master) or the responder (target) of the current transaction.

Parity for any clock is always the parity of the bus as sampled on the previous edge. The output enable follows the handshake: the master drives parity for the address and write data, and the target drives it for read data. When the agent receives data, it compares the incoming parity one clock after the data phase completes. A mismatch produces an active-low error pulse two edges later, with its own drive enable. The parity error line is held high for one extra clock before it is released. A sticky flag records every parity error detected, including errors that the error line must not report.

Top module: `bus_parity_unit`

## Requirements
- R1: While reset is asserted and after its release with an idle bus, parOe, par64Oe and perrOe are 0, perrN is 1 and parErrSeen is 0. A later reset clears parErrSeen.
- R2: In every clock, parOut equals the XOR of ad[31:0] and cbeN[3:0] sampled at the previous edge, and par64Out equals the XOR of ad[63:32] and cbeN[7:4]. This makes the total count of ones over each lane plus its parity bit even.
- R3: An address phase is an edge with frameN low while no transaction is open, and cbeN[3:0] at that edge is the command. When isMaster is 1, parOe is 1 in the clock after the address phase. par64Oe is also 1 when req64N is low at that edge. When isMaster is 0, neither is driven.
- R4: For a write command (cbeN[0]=1 at the address phase) with isMaster=1, parOe is 1 in the clock after each data-phase edge with irdyN low, and 0 after a data-phase edge with irdyN high. par64Oe follows the same rule when req64N was low at the address phase and ack64N is low.
- R5: For a read command (cbeN[0]=0) with isMaster=0, parOe (and par64Oe under the 64-bit condition of R4) is 1 in the clock after each data-phase edge with trdyN low. A master reading never drives parity during data phases.
- R6: A data phase completes on an edge k with irdyN and trdyN both low. When the block is the receiver (target on a write, master on a read) and devselN is low at edge k, a mismatch of parIn at edge k+1 against R2 makes perrN 0, with perrOe 1, for exactly the clock after edge k+2. Phases the block drives itself, and phases completing with devselN high, never lower perrN.
- R7: After the last clock with perrN at 0, perrOe stays 1 for one more clock with perrN at 1, then falls to 0. Back-to-back failing phases keep perrN low for consecutive clocks.
- R8: For the special cycle command 4'b0001, a data parity mismatch never lowers perrN, but it still sets parErrSeen.
- R9: The upper lane is checked (par64In against par64Out) only when req64N was low at the address phase and ack64N is low at the completing edge. Otherwise an upper-lane mismatch has no effect on perrN or parErrSeen.
- R10: parErrSeen becomes 1 in the clock after edge k+1 when a receiver data mismatch is detected. It also becomes 1 after a mismatch of parIn one edge after an address phase with isMaster=0. Such an address error never lowers perrN. The flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 when this agent initiates the current transaction |
| frameN | input | 1 | Sampled transaction frame, active low |
| irdyN | input | 1 | Sampled initiator ready, active low |
| trdyN | input | 1 | Sampled target ready, active low |
| devselN | input | 1 | Sampled device select, active low |
| req64N | input | 1 | Sampled 64-bit transfer request, active low |
| ack64N | input | 1 | Sampled 64-bit transfer acknowledge, active low |
| cbeN | input | 8 | Sampled command / byte enables, both lanes |
| ad | input | 64 | Sampled address/data, both lanes |
| parIn | input | 1 | Sampled lower-lane parity line |
| par64In | input | 1 | Sampled upper-lane parity line |
| parOut | output | 1 | Lower-lane parity to drive |
| parOe | output | 1 | Drive enable for parOut |
| par64Out | output | 1 | Upper-lane parity to drive |
| par64Oe | output | 1 | Drive enable for par64Out |
| perrN | output | 1 | Data parity error, active low |
| perrOe | output | 1 | Drive enable for perrN |
| parErrSeen | output | 1 | Sticky record of any detected parity error |

## Verification
If the open-transaction flag or the latched command goes wrong, the parity enables show it within one clock: they rise in the wrong role or fail to drop after the last phase. Such a fault can also report an error for a phase the agent drove itself. If the check pipeline is corrupted, the perrN pulse lands at the wrong edge or has the wrong length. A broken release stage shows up in perrOe one clock after perrN rises. Faults in the 64-bit qualifier or the special-cycle filter only become visible when an upper-lane mismatch or a special-cycle mismatch is injected. The bench therefore injects exactly those cases and watches perrN two edges after completion.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;

  localparam logic [3:0] CMD_SPECIAL = 4'b0001;

  // Per-edge strobes from the phase tracker to the parity datapath.
  typedef struct packed {
    logic driveLo;    // drive lower-lane parity next clock
    logic driveHi;    // drive upper-lane parity next clock
    logic checkAddr;  // compare address parity next edge
    logic checkData;  // compare data parity next edge
    logic checkWide;  // include upper lane in that compare
    logic reportOk;   // a data mismatch may lower the error line
  } parStrobe_t;

endpackage

// File: rtl/parity_phase_ctrl.sv
module parity_phase_ctrl
  import bus_parity_pkg::*;
#(
  parameter int BE_W    = 4,
  parameter bit WIDE_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            isMaster,
  input  logic            frameN,
  input  logic            irdyN,
  input  logic            trdyN,
  input  logic            devselN,
  input  logic            req64N,
  input  logic            ack64N,
  input  logic [BE_W-1:0] cmdIn,
  output parStrobe_t      strobe
);

  logic            busy;
  logic [BE_W-1:0] cmdReg;
  logic            wideReg;

  logic addrPhase;
  logic isWrite;
  logic isSpecial;
  logic phaseDone;
  logic ownDrive;
  logic receiver;

  always_comb begin
    addrPhase = !busy && !frameN;
    isWrite   = cmdReg[0];
    isSpecial = (cmdReg[3:0] == CMD_SPECIAL);
    phaseDone = busy && !irdyN && !trdyN;
    ownDrive  = busy && ((isMaster && isWrite && !irdyN) ||
                         (!isMaster && !isWrite && !trdyN));
    receiver  = (isMaster && !isWrite) || (!isMaster && isWrite);

    strobe.driveLo   = (addrPhase && isMaster) || ownDrive;
    strobe.driveHi   = WIDE_EN &&
                       ((addrPhase && isMaster && !req64N) ||
                        (ownDrive && wideReg && !ack64N));
    strobe.checkAddr = addrPhase && !isMaster;
    strobe.checkData = phaseDone && receiver;
    strobe.checkWide = WIDE_EN && wideReg && !ack64N;
    strobe.reportOk  = !devselN && !isSpecial;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cmdReg  <= '0;
      wideReg <= 1'b0;
    end else if (addrPhase) begin
      busy    <= 1'b1;
      cmdReg  <= cmdIn;
      wideReg <= !req64N;
    end else if (busy && frameN && (irdyN || phaseDone)) begin
      busy    <= 1'b0;
    end
  end

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdReg)); // R8

endmodule

// File: rtl/parity_datapath.sv
module parity_datapath
  import bus_parity_pkg::*;
#(
  parameter int LANE_W  = 32,
  parameter int BE_W    = 4,
  parameter bit WIDE_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*LANE_W-1:0] ad,
  input  logic [2*BE_W-1:0]   cbeN,
  input  logic                parIn,
  input  logic                par64In,
  input  parStrobe_t          strobe,
  output logic                parOut,
  output logic                parOe,
  output logic                par64Out,
  output logic                par64Oe,
  output logic                perrN,
  output logic                perrOe,
  output logic                errSticky
);

  localparam int LANES = WIDE_EN ? 2 : 1;

  logic laneDrive [2];
  logic parBit    [2];
  logic oeBit     [2];

  assign laneDrive[0] = strobe.driveLo;
  assign laneDrive[1] = strobe.driveHi;

  for (genvar g = 0; g < 2; g++) begin : gLane
    if (g < LANES) begin : gOn
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          parBit[g] <= 1'b0;
          oeBit[g]  <= 1'b0;
        end else begin
          parBit[g] <= ^{ad[g*LANE_W +: LANE_W], cbeN[g*BE_W +: BE_W]};
          oeBit[g]  <= laneDrive[g];
        end
      end
    end else begin : gOff
      assign parBit[g] = 1'b0;
      assign oeBit[g]  = 1'b0;
    end
  end

  logic pendAddr, pendData, pendWide, pendReport;
  logic errDet;
  logic perrNReg, perrOeReg, sticky;
  logic mmLo, mmHi, dataErr, addrErr;

  always_comb begin
    mmLo    = parBit[0] ^ parIn;
    mmHi    = parBit[1] ^ par64In;
    dataErr = pendData && (mmLo || (pendWide && mmHi));
    addrErr = pendAddr && mmLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr   <= 1'b0;
      pendData   <= 1'b0;
      pendWide   <= 1'b0;
      pendReport <= 1'b0;
      errDet     <= 1'b0;
      perrNReg   <= 1'b1;
      perrOeReg  <= 1'b0;
      sticky     <= 1'b0;
    end else begin
      pendAddr   <= strobe.checkAddr;
      pendData   <= strobe.checkData;
      pendWide   <= strobe.checkWide;
      pendReport <= strobe.reportOk;
      errDet     <= dataErr && pendReport;
      perrNReg   <= !errDet;
      perrOeReg  <= errDet || (perrOeReg && !perrNReg);
      sticky     <= sticky || dataErr || addrErr;
    end
  end

  assign parOut    = parBit[0];
  assign parOe     = oeBit[0];
  assign par64Out  = parBit[1];
  assign par64Oe   = oeBit[1];
  assign perrN     = perrNReg;
  assign perrOe    = perrOeReg;
  assign errSticky = sticky;

  AST_PERR_AFTER_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (dataErr && pendReport) |=> ##1 !perrNReg); // R6
  AST_PERR_LOW_IS_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !perrNReg |-> perrOeReg); // R6
  AST_PERR_PARKED_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perrNReg) |-> perrOeReg); // R7
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    sticky |=> sticky); // R10
  AST_ADDR_ERR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |=> ##1 perrNReg); // R10

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bus_parity_pkg::*;
#(
  parameter int LANE_W  = 32,
  parameter int BE_W    = 4,
  parameter bit WIDE_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                isMaster,
  input  logic                frameN,
  input  logic                irdyN,
  input  logic                trdyN,
  input  logic                devselN,
  input  logic                req64N,
  input  logic                ack64N,
  input  logic [2*BE_W-1:0]   cbeN,
  input  logic [2*LANE_W-1:0] ad,
  input  logic                parIn,
  input  logic                par64In,
  output logic                parOut,
  output logic                parOe,
  output logic                par64Out,
  output logic                par64Oe,
  output logic                perrN,
  output logic                perrOe,
  output logic                parErrSeen
);

  parStrobe_t strobe;

  parity_phase_ctrl #(
    .BE_W    (BE_W),
    .WIDE_EN (WIDE_EN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .isMaster (isMaster),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .trdyN    (trdyN),
    .devselN  (devselN),
    .req64N   (req64N),
    .ack64N   (ack64N),
    .cmdIn    (cbeN[BE_W-1:0]),
    .strobe   (strobe)
  );

  parity_datapath #(
    .LANE_W  (LANE_W),
    .BE_W    (BE_W),
    .WIDE_EN (WIDE_EN)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ad        (ad),
    .cbeN      (cbeN),
    .parIn     (parIn),
    .par64In   (par64In),
    .strobe    (strobe),
    .parOut    (parOut),
    .parOe     (parOe),
    .par64Out  (par64Out),
    .par64Oe   (par64Oe),
    .perrN     (perrN),
    .perrOe    (perrOe),
    .errSticky (parErrSeen)
  );

endmodule

// File: tb/bus_parity_unit_bench.sv
`timescale 1ns/1ps
module bus_parity_unit_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b0;
  logic frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1, devselN = 1'b1;
  logic req64N = 1'b1, ack64N = 1'b1;
  logic [7:0]  cbeN = '0;
  logic [63:0] ad = '0;
  logic parIn = 1'b0, par64In = 1'b0;
  logic parOut, parOe, par64Out, par64Oe, perrN, perrOe, parErrSeen;

  bus_parity_unit u_bus_parity_unit (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN), .devselN(devselN),
    .req64N(req64N), .ack64N(ack64N), .cbeN(cbeN), .ad(ad),
    .parIn(parIn), .par64In(par64In),
    .parOut(parOut), .parOe(parOe), .par64Out(par64Out), .par64Oe(par64Oe),
    .perrN(perrN), .perrOe(perrOe), .parErrSeen(parErrSeen)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    cyc;
    int    sel;
    logic  exp;
    string tag;
  } item_t;

  item_t expQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  logic [63:0] prevD = '0;
  logic [7:0]  prevCbe = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic plo(logic [63:0] d, logic [7:0] c);
    return ^{d[31:0], c[3:0]};
  endfunction
  function automatic logic phi(logic [63:0] d, logic [7:0] c);
    return ^{d[63:32], c[7:4]};
  endfunction

  function automatic logic getSig(int sel);
    case (sel)
      0: return parOut;
      1: return parOe;
      2: return par64Out;
      3: return par64Oe;
      4: return perrN;
      5: return perrOe;
      default: return parErrSeen;
    endcase
  endfunction

  function automatic string sigName(int sel);
    case (sel)
      0: return "parOut";
      1: return "parOe";
      2: return "par64Out";
      3: return "par64Oe";
      4: return "perrN";
      5: return "perrOe";
      default: return "parErrSeen";
    endcase
  endfunction

  task automatic compare(int sel, logic exp, string tag);
    nChecks++;
    if (getSig(sel) !== exp) begin
      nFail++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b",
               tag, sigName(sel), cyc, getSig(sel), exp);
    end
  endtask

  task automatic push(int c, int sel, logic exp, string tag);
    item_t it;
    it.cyc = c; it.sel = sel; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: pops every expectation due in the current cycle.
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].cyc == cyc) begin
        compare(expQ[i].sel, expQ[i].exp, expQ[i].tag);
        expQ.delete(i);
      end
    end
  end

  // Driver: one bus clock; returns the number of the edge that samples it.
  task automatic drv(input logic fr, ir, tr, dv, r64, a64,
                     input logic [7:0] c, input logic [63:0] d,
                     input logic fLo, fHi, output int e);
    @(negedge clk);
    frameN = fr; irdyN = ir; trdyN = tr; devselN = dv;
    req64N = r64; ack64N = a64; cbeN = c; ad = d;
    parIn   = plo(prevD, prevCbe) ^ fLo;
    par64In = phi(prevD, prevCbe) ^ fHi;
    prevD = d; prevCbe = c;
    e = cyc + 1;
  endtask

  task automatic idle(input logic fLo, fHi, output int e);
    drv(1, 1, 1, 1, 1, 1, 8'h00, 64'h0, fLo, fHi, e);
  endtask

  task automatic doReset();
    int e;
    @(negedge clk);
    rstN = 1'b0;
    frameN = 1; irdyN = 1; trdyN = 1; devselN = 1; req64N = 1; ack64N = 1;
    cbeN = '0; ad = '0; parIn = 0; par64In = 0; prevD = '0; prevCbe = '0;
    repeat (2) @(negedge clk);
    compare(1, 1'b0, "R1");
    compare(5, 1'b0, "R1");
    compare(4, 1'b1, "R1");
    compare(6, 1'b0, "R1");
    rstN = 1'b1;
    idle(0, 0, e);
    push(e, 1, 1'b0, "R1");
    push(e, 3, 1'b0, "R1");
    push(e, 6, 1'b0, "R1");
  endtask

  task automatic settle();
    int e;
    repeat (6) idle(0, 0, e);
  endtask

  localparam logic [63:0] A1 = 64'hA5C3_1F00_0000_1234;
  localparam logic [63:0] D1 = 64'h0F0F_7777_8001_00FE;
  localparam logic [63:0] D2 = 64'h1357_9BDF_2468_ACE1;
  localparam logic [63:0] D3 = 64'hFFFF_0001_0000_0007;

  initial begin
    #1000000;
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int a, e, k;
    doReset();

    // Master write, 32-bit, one wait state, own phases are never checked
    isMaster = 1'b1;
    drv(0, 1, 1, 1, 1, 1, 8'h07, A1, 0, 0, a);
    push(a, 1, 1'b1, "R3");
    push(a, 0, plo(A1, 8'h07), "R2");
    push(a, 3, 1'b0, "R3");
    drv(0, 1, 1, 0, 1, 1, 8'h00, D2, 0, 0, e);
    push(e, 1, 1'b0, "R4");
    drv(0, 0, 1, 0, 1, 1, 8'h00, D1, 0, 0, e);
    push(e, 1, 1'b1, "R4");
    push(e, 0, plo(D1, 8'h00), "R2");
    drv(1, 0, 0, 0, 1, 1, 8'h00, D1, 1, 0, k);
    push(k, 1, 1'b1, "R4");
    idle(1, 1, e);
    push(e, 1, 1'b0, "R4");
    push(k + 1, 6, 1'b0, "R6");
    push(k + 2, 4, 1'b1, "R6");
    settle();

    // Target read, 64-bit, target drives both lanes
    doReset();
    isMaster = 1'b0;
    drv(0, 1, 1, 1, 0, 1, 8'h06, A1, 0, 0, a);
    push(a, 1, 1'b0, "R3");
    push(a, 3, 1'b0, "R3");
    drv(0, 1, 1, 0, 0, 0, 8'h00, D2, 0, 0, e);
    push(e, 1, 1'b0, "R5");
    push(e, 6, 1'b0, "R10");
    drv(1, 0, 0, 0, 0, 0, 8'h30, D1, 0, 0, k);
    push(k, 1, 1'b1, "R5");
    push(k, 3, 1'b1, "R5");
    push(k, 0, plo(D1, 8'h30), "R2");
    push(k, 2, phi(D1, 8'h30), "R2");
    idle(0, 0, e);
    push(e, 1, 1'b0, "R5");
    push(e, 3, 1'b0, "R5");
    settle();

    // Target write, two back-to-back failing phases
    doReset();
    isMaster = 1'b0;
    drv(0, 1, 1, 1, 1, 1, 8'h07, A1, 0, 0, a);
    drv(0, 0, 0, 0, 1, 1, 8'h00, D1, 0, 0, k);
    push(k, 1, 1'b0, "R6");
    drv(1, 0, 0, 0, 1, 1, 8'h00, D2, 1, 0, e);
    idle(1, 0, e);
    push(k + 1, 6, 1'b1, "R10");
    push(k + 1, 4, 1'b1, "R6");
    push(k + 2, 4, 1'b0, "R6");
    push(k + 2, 5, 1'b1, "R6");
    push(k + 3, 4, 1'b0, "R7");
    push(k + 4, 4, 1'b1, "R7");
    push(k + 4, 5, 1'b1, "R7");
    push(k + 5, 5, 1'b0, "R7");
    settle();

    // Target write completing with devselN high: not claimed, no report
    doReset();
    isMaster = 1'b0;
    drv(0, 1, 1, 1, 1, 1, 8'h07, A1, 0, 0, a);
    drv(1, 0, 0, 1, 1, 1, 8'h00, D3, 0, 0, k);
    idle(1, 0, e);
    push(k + 2, 4, 1'b1, "R6");
    push(k + 2, 5, 1'b0, "R6");
    push(k + 1, 6, 1'b1, "R10");
    settle();

    // Master read, 64-bit, upper-lane mismatch is reported
    doReset();
    isMaster = 1'b1;
    drv(0, 1, 1, 1, 0, 1, 8'h06, A1, 0, 0, a);
    push(a, 1, 1'b1, "R3");
    push(a, 3, 1'b1, "R3");
    push(a, 2, phi(A1, 8'h06), "R2");
    drv(1, 0, 0, 0, 0, 0, 8'h00, D2, 0, 0, k);
    push(k, 1, 1'b0, "R5");
    idle(0, 1, e);
    push(k + 1, 6, 1'b1, "R9");
    push(k + 2, 4, 1'b0, "R9");
    settle();

    // Master read, 32-bit answer: upper-lane mismatch ignored
    doReset();
    isMaster = 1'b1;
    drv(0, 1, 1, 1, 0, 1, 8'h06, A1, 0, 0, a);
    drv(1, 0, 0, 0, 0, 1, 8'h00, D2, 0, 0, k);
    idle(0, 1, e);
    push(k + 1, 6, 1'b0, "R9");
    push(k + 2, 4, 1'b1, "R9");
    settle();

    // Special cycle: never reported, still recorded
    doReset();
    isMaster = 1'b0;
    drv(0, 1, 1, 1, 1, 1, 8'h01, A1, 0, 0, a);
    drv(1, 0, 0, 0, 1, 1, 8'h00, D3, 0, 0, k);
    idle(1, 0, e);
    push(k + 1, 6, 1'b1, "R8");
    push(k + 2, 4, 1'b1, "R8");
    push(k + 2, 5, 1'b0, "R8");
    settle();

    // Address parity error seen as target: status only
    doReset();
    isMaster = 1'b0;
    drv(0, 1, 1, 1, 1, 1, 8'h07, A1, 0, 0, a);
    drv(0, 1, 1, 0, 1, 1, 8'h00, D1, 1, 0, e);
    push(a + 1, 6, 1'b1, "R10");
    drv(1, 0, 0, 0, 1, 1, 8'h00, D1, 0, 0, k);
    push(a + 2, 4, 1'b1, "R10");
    push(a + 2, 5, 1'b0, "R10");
    idle(0, 0, e);
    push(k + 2, 4, 1'b1, "R10");
    settle();

    // A new reset clears the sticky flag
    doReset();
    settle();

    nChecks += expQ.size();
    nFail += expQ.size();
    foreach (expQ[i]) $display("FAIL %s %s never sampled: actual none expected %b",
                               expQ[i].tag, sigName(expQ[i].sel), expQ[i].exp);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule